// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs processor-side bus cycles over a pin set on which address, status and data share the same wires. A cycle request carries a 20-bit address, a direction flag, a size flag (byte or word), write data, an address-space selector and a 2-bit segment code. Once a request is accepted, the sequencer steps through the bus states T1, T2, T3, optional wait states and T4. In each state it drives the shared address/data lanes, the four upper address/status lines, an address strobe, an active-low high-byte enable, an active-low data-buffer enable and a 3-bit cycle-type code.

Every bus state lasts two clocks, a first half and a second half. This lets the data-buffer enable open and close in the middle of a state without falling-edge logic. The ready input is sampled at the end of the second half of T3 and of each wait state. While ready is low, wait states repeat and the T3 pin values are held. A new request can be accepted at the moment ready lets the current cycle move to T4. The cycle-type code of that queued cycle then appears during T4 of the current cycle, and its T1 follows T4 with no idle state between them.

The address-space selector uses this encoding: 00 memory, 01 I/O, 10 code fetch, 11 interrupt acknowledge.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset and in idle, the pins sit at these values: ale=0, ad_oe=0, den_n=1, bhe_n=1, sts=111 and req_ready=1.
- R2: An accepted request from idle starts T1 on the next clock. Each bus state lasts two clocks, in the order T1, T2, T3, T4, so a cycle without waits takes 8 clocks.
- R3: During both clocks of T1, ale=1, ad_oe=1, ad_out carries address bits 15..0 and a_hi carries address bits 19..16.
- R4: From T2 through T4, a_hi carries status. Bits 1..0 hold the segment code and bits 3..2 are 0, so the top line is always low in this phase.
- R5: In T1, bhe_n is 0 exactly when the cycle is word-wide or the address is odd. In every other state bhe_n is 1.
- R6: den_n is 0 from the second clock of T2 through the first clock of T4, including every wait state. Otherwise den_n is 1.
- R7: sts shows the cycle-type code during T1 and T2 of a cycle. It also shows that code during T4 of the preceding cycle when the cycle was queued behind it. At all other times sts is 111. The codes are: interrupt acknowledge 000, I/O read 001, I/O write 010, code fetch 100, memory read 101, memory write 110.
- R8: ready is sampled on the second clock of T3 and of each wait state. When ready is low, a two-clock wait state follows, and ad_out, ad_oe, a_hi and den_n keep their T3 values.
- R9: A write drives ad_out (ad_oe=1) from T2 through T4. A word places the data as is. An even-address byte places the byte on bits 7..0 with bits 15..8 at zero. An odd-address byte places the byte on bits 15..8 with bits 7..0 at zero. A read releases the lanes (ad_oe=0) from T2 through T4.
- R10: A read captures ad_in on the clock edge that ends the last T3/wait state. rd_valid then pulses for the first clock of T4. rd_data holds the full word for a word read, or the selected lane zero-extended for a byte read (bits 7..0 for an even address, bits 15..8 for an odd one).
- R11: req_ready is 1 in idle. During a cycle it is 1 only on the second clock of T3 or of a wait state while ready is 1. A request accepted there starts its T1 directly after T4.
- R12: Code-fetch and interrupt-acknowledge cycles behave as reads whatever the write flag says: the lanes are released, data is captured and their codes apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; two clocks per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Request accepted on this clock edge when valid |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word-wide, 0 byte-wide |
| req_space | input | 2 | 00 memory, 01 I/O, 10 code fetch, 11 interrupt acknowledge |
| req_seg | input | 2 | Segment code placed on the status lines |
| req_wdata | input | 16 | Write data (byte cycles use bits 7..0) |
| ready | input | 1 | Slave ready; low inserts wait states |
| ad_in | input | 16 | Value sensed on the shared lanes |
| ad_out | output | 16 | Value driven onto the shared lanes |
| ad_oe | output | 1 | Lane output enable |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Active-low high-byte enable |
| den_n | output | 1 | Active-low data-buffer enable |
| sts | output | 3 | Cycle-type status |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read data |

## Verification
The assertions assume that ready is only meaningful when it is sampled, and that req_valid with its fields stays stable until req_ready takes it. The stimulus drives every input on the falling clock edge. It holds a request until it is accepted and offers a queued request only in the half-state where acceptance is possible. It raises ready only after the chosen number of wait states, so every stall pattern follows the sampling rule. Randomly chosen spaces, sizes, odd and even addresses and wait counts are mixed with directed cases: an odd-byte write, a long stall, and queued chains that include interrupt-acknowledge and code-fetch cycles with the write flag set.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  localparam logic [1:0] SP_MEM   = 2'd0;
  localparam logic [1:0] SP_IO    = 2'd1;
  localparam logic [1:0] SP_FETCH = 2'd2;
  localparam logic [1:0] SP_INTA  = 2'd3;

  localparam logic [2:0] STS_PASSIVE = 3'b111;

  // only memory and I/O cycles may carry write data
  function automatic logic drives_data(input logic [1:0] space, input logic wr);
    return wr && (space == SP_MEM || space == SP_IO);
  endfunction

  function automatic logic [2:0] cycle_code(input logic [1:0] space, input logic wr);
    logic [2:0] code;
    case (space)
      SP_INTA:  code = 3'b000;
      SP_FETCH: code = 3'b100;
      SP_IO:    code = wr ? 3'b010 : 3'b001;
      default:  code = wr ? 3'b110 : 3'b101;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/mbus_tstate_ctrl.sv
module mbus_tstate_ctrl
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  input  logic    chain_pending,
  output tstate_e state,
  output logic    phase,
  output logic    sample_edge,
  output logic    cycle_end
);

  tstate_e state_d;
  logic    phase_d;

  always_comb begin
    sample_edge = phase && (state == TS_T3 || state == TS_TW);
    cycle_end   = phase && (state == TS_T4);
  end

  always_comb begin
    state_d = state;
    phase_d = (state == TS_IDLE) ? 1'b0 : ~phase;
    unique case (state)
      TS_IDLE: if (start) state_d = TS_T1;
      TS_T1:   if (phase) state_d = TS_T2;
      TS_T2:   if (phase) state_d = TS_T3;
      TS_T3,
      TS_TW:   if (phase) state_d = ready ? TS_T4 : TS_TW;
      TS_T4:   if (phase) state_d = chain_pending ? TS_T1 : TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TS_IDLE;
      phase <= 1'b0;
    end else begin
      state <= state_d;
      phase <= phase_d;
    end
  end

endmodule

// File: rtl/mbus_cycle_regs.sv
module mbus_cycle_regs #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_now,
  input  logic              take_next,
  input  logic              cycle_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [1:0]        req_space,
  input  logic [1:0]        req_seg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic              cur_word,
  output logic [1:0]        cur_space,
  output logic [1:0]        cur_seg,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              nxt_valid,
  output logic [1:0]        nxt_space,
  output logic              nxt_write
);

  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_word;
  logic [1:0]        nxt_seg;
  logic [DATA_W-1:0] nxt_wdata;
  logic              promote;
  logic              cur_en;

  always_comb begin
    promote = cycle_end && nxt_valid;
    cur_en  = take_now || promote;
  end

  // active cycle descriptor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_word  <= 1'b0;
      cur_space <= '0;
      cur_seg   <= '0;
      cur_wdata <= '0;
    end else if (cur_en) begin
      if (take_now) begin
        cur_addr  <= req_addr;
        cur_write <= req_write;
        cur_word  <= req_word;
        cur_space <= req_space;
        cur_seg   <= req_seg;
        cur_wdata <= req_wdata;
      end else begin
        cur_addr  <= nxt_addr;
        cur_write <= nxt_write;
        cur_word  <= nxt_word;
        cur_space <= nxt_space;
        cur_seg   <= nxt_seg;
        cur_wdata <= nxt_wdata;
      end
    end
  end

  // queued cycle descriptor, filled at the end of T3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_addr  <= '0;
      nxt_write <= 1'b0;
      nxt_word  <= 1'b0;
      nxt_space <= '0;
      nxt_seg   <= '0;
      nxt_wdata <= '0;
    end else if (take_next) begin
      nxt_addr  <= req_addr;
      nxt_write <= req_write;
      nxt_word  <= req_word;
      nxt_space <= req_space;
      nxt_seg   <= req_seg;
      nxt_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nxt_valid <= 1'b0;
    else if (take_next) nxt_valid <= 1'b1;
    else if (promote)   nxt_valid <= 1'b0;
  end

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  tstate_e                   state,
  input  logic                      phase,
  input  logic [ADDR_W-1:0]         cur_addr,
  input  logic                      cur_write,
  input  logic                      cur_word,
  input  logic [1:0]                cur_space,
  input  logic [1:0]                cur_seg,
  input  logic [DATA_W-1:0]         cur_wdata,
  input  logic                      nxt_valid,
  input  logic [1:0]                nxt_space,
  input  logic                      nxt_write,
  output logic [DATA_W-1:0]         ad_out,
  output logic                      ad_oe,
  output logic [ADDR_W-DATA_W-1:0]  a_hi,
  output logic                      ale,
  output logic                      bhe_n,
  output logic                      den_n,
  output logic [2:0]                sts
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int BYTE_W = DATA_W / 2;

  logic              in_t1;
  logic              in_data_phase;
  logic              wr_cycle;
  logic [DATA_W-1:0] lane_data;
  logic [HI_W-1:0]   status_field;

  always_comb begin
    in_t1         = (state == TS_T1);
    in_data_phase = (state == TS_T2) || (state == TS_T3) ||
                    (state == TS_TW) || (state == TS_T4);
    wr_cycle      = drives_data(cur_space, cur_write);
    status_field  = {{(HI_W-2){1'b0}}, cur_seg};
  end

  // byte steering onto the lane selected by address bit 0
  always_comb begin
    if (cur_word)
      lane_data = cur_wdata;
    else if (cur_addr[0])
      lane_data = {cur_wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
    else
      lane_data = {{BYTE_W{1'b0}}, cur_wdata[BYTE_W-1:0]};
  end

  always_comb begin
    ale   = in_t1;
    ad_oe = in_t1 || (in_data_phase && wr_cycle);
    if (in_t1)
      ad_out = cur_addr[DATA_W-1:0];
    else if (in_data_phase && wr_cycle)
      ad_out = lane_data;
    else
      ad_out = '0;

    if (in_t1)
      a_hi = cur_addr[ADDR_W-1:DATA_W];
    else if (in_data_phase)
      a_hi = status_field;
    else
      a_hi = '0;

    bhe_n = in_t1 ? !(cur_word || cur_addr[0]) : 1'b1;

    den_n = !((state == TS_T2 && phase) || state == TS_T3 ||
              state == TS_TW || (state == TS_T4 && !phase));

    if (in_t1 || state == TS_T2)
      sts = cycle_code(cur_space, cur_write);
    else if (state == TS_T4 && nxt_valid)
      sts = cycle_code(nxt_space, nxt_write);
    else
      sts = STS_PASSIVE;
  end

endmodule

// File: rtl/mbus_read_capture.sv
module mbus_read_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              cur_word,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] picked;

  always_comb begin
    if (cur_word)
      picked = ad_in;
    else if (addr_lsb)
      picked = {{BYTE_W{1'b0}}, ad_in[DATA_W-1:BYTE_W]};
    else
      picked = {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= picked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [1:0]               req_space,
  input  logic [1:0]               req_seg,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     bhe_n,
  output logic                     den_n,
  output logic [2:0]               sts,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);

  logic              rst_meta_n;
  logic              rst_sync_n;
  tstate_e           st_q;
  logic              ph_q;
  logic              sample_edge;
  logic              cycle_end;
  logic              accept;
  logic              take_now;
  logic              take_next;
  logic              capture;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic              cur_word;
  logic [1:0]        cur_space;
  logic [1:0]        cur_seg;
  logic [DATA_W-1:0] cur_wdata;
  logic              nxt_valid;
  logic [1:0]        nxt_space;
  logic              nxt_write;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    req_ready = (st_q == TS_IDLE) || (sample_edge && ready);
    accept    = req_valid && req_ready;
    take_now  = accept && (st_q == TS_IDLE);
    take_next = accept && (st_q != TS_IDLE);
    capture   = sample_edge && ready && !drives_data(cur_space, cur_write);
  end

  mbus_tstate_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start         (take_now),
    .ready         (ready),
    .chain_pending (nxt_valid),
    .state         (st_q),
    .phase         (ph_q),
    .sample_edge   (sample_edge),
    .cycle_end     (cycle_end)
  );

  mbus_cycle_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take_now  (take_now),
    .take_next (take_next),
    .cycle_end (cycle_end),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_word  (req_word),
    .req_space (req_space),
    .req_seg   (req_seg),
    .req_wdata (req_wdata),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_word  (cur_word),
    .cur_space (cur_space),
    .cur_seg   (cur_seg),
    .cur_wdata (cur_wdata),
    .nxt_valid (nxt_valid),
    .nxt_space (nxt_space),
    .nxt_write (nxt_write)
  );

  mbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state     (st_q),
    .phase     (ph_q),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_word  (cur_word),
    .cur_space (cur_space),
    .cur_seg   (cur_seg),
    .cur_wdata (cur_wdata),
    .nxt_valid (nxt_valid),
    .nxt_space (nxt_space),
    .nxt_write (nxt_write),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .bhe_n     (bhe_n),
    .den_n     (den_n),
    .sts       (sts)
  );

  mbus_read_capture #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .capture  (capture),
    .cur_word (cur_word),
    .addr_lsb (cur_addr[0]),
    .ad_in    (ad_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input tstate_e                  state,
  input logic                     req_ready,
  input logic                     ready,
  input logic [DATA_W-1:0]        ad_out,
  input logic                     ad_oe,
  input logic [ADDR_W-DATA_W-1:0] a_hi,
  input logic                     ale,
  input logic                     bhe_n,
  input logic                     den_n,
  input logic [2:0]               sts,
  input logic                     rd_valid
);

  localparam int HI_W = ADDR_W - DATA_W;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_IDLE) |-> (sts == STS_PASSIVE && !ad_oe && den_n && bhe_n && !ale));

  // R3
  strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && sts != STS_PASSIVE));

  // R4
  status_top_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (a_hi[HI_W-1] == 1'b0));

  // R6
  buffer_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> !ale);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_TW) |-> ($stable(ad_out) && $stable(ad_oe) && $stable(den_n) && $stable(a_hi)));

  // R10
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R11
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && state != TS_IDLE) |-> ready);

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (st_q),
  .req_ready (req_ready),
  .ready     (ready),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .a_hi      (a_hi),
  .ale       (ale),
  .bhe_n     (bhe_n),
  .den_n     (den_n),
  .sts       (sts),
  .rd_valid  (rd_valid)
);

// File: tb/mbus_cycle_seq_test.sv
module mbus_cycle_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_addr;
  logic        req_write;
  logic        req_word;
  logic [1:0]  req_space;
  logic [1:0]  req_seg;
  logic [15:0] req_wdata;
  logic        ready;
  logic [15:0] ad_in;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  a_hi;
  logic        ale;
  logic        bhe_n;
  logic        den_n;
  logic [2:0]  sts;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mbus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_space(req_space), .req_seg(req_seg), .req_wdata(req_wdata),
    .ready(ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_hi(a_hi), .ale(ale), .bhe_n(bhe_n), .den_n(den_n), .sts(sts),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [1:0] sp, input logic wr);
    if (sp == 2'd3) return 3'b000;
    if (sp == 2'd2) return 3'b100;
    if (sp == 2'd1) return wr ? 3'b010 : 3'b001;
    return wr ? 3'b110 : 3'b101;
  endfunction

  function automatic logic [15:0] exp_lane(input logic wd, input logic a0, input logic [15:0] d);
    if (wd) return d;
    if (a0) return {d[7:0], 8'h00};
    return {8'h00, d[7:0]};
  endfunction

  function automatic logic [15:0] exp_rd(input logic wd, input logic a0, input logic [15:0] d);
    if (wd) return d;
    if (a0) return {8'h00, d[15:8]};
    return {8'h00, d[7:0]};
  endfunction

  // one bus cycle; pre=1 means it was already queued behind the previous one
  task automatic run_cycle(
    input logic [1:0] sp, input logic wr, input logic wd, input logic [19:0] ad,
    input logic [15:0] wdat, input logic [1:0] sg, input int waits,
    input logic [15:0] din, input bit pre, input bit chain,
    input logic [1:0] csp, input logic cwr, input logic cwd, input logic [19:0] cad,
    input logic [15:0] cwdat, input logic [1:0] csg);
    logic iswr;
    int   last;
    iswr = wr && (sp < 2'd2);
    last = 7 + 2*waits;
    if (!pre) begin
      @(negedge clk);
      ready = 1'b0;
      chk("R11 req_ready in idle", req_ready, 1);
      req_space = sp; req_write = wr; req_word = wd; req_addr = ad;
      req_wdata = wdat; req_seg = sg; req_valid = 1'b1;
    end
    for (int n = 0; n <= last; n++) begin
      int  ts;
      bit  ph;
      @(negedge clk);
      if (n == 0 && !pre) req_valid = 1'b0;
      ready = (n >= 4 + 2*waits);
      ad_in = din;
      if (chain && n == 4 + 2*waits) begin
        req_space = csp; req_write = cwr; req_word = cwd; req_addr = cad;
        req_wdata = cwdat; req_seg = csg; req_valid = 1'b1;
      end
      if (chain && n == 6 + 2*waits) req_valid = 1'b0;
      #1;
      ph = n[0];
      ts = (n < 2) ? 1 : (n < 4) ? 2 : (n < 6) ? 3 : (n < 6 + 2*waits) ? 4 : 5;
      chk("R2/R3 ale", ale, ts == 1);
      chk("R9 ad_oe", ad_oe, (ts == 1) || iswr);
      if (ts == 1) begin
        chk("R3 ad_out address", ad_out, ad[15:0]);
        chk("R3 a_hi address", a_hi, ad[19:16]);
        chk("R5 bhe_n in T1", bhe_n, !(wd || ad[0]));
      end else begin
        chk("R4 a_hi status", a_hi, {2'b00, sg});
        chk("R5 bhe_n after T1", bhe_n, 1);
        if (iswr) chk("R9 write lane", ad_out, exp_lane(wd, ad[0], wdat));
      end
      chk("R6 den_n", den_n, !((ts == 2 && ph) || ts == 3 || ts == 4 || (ts == 5 && !ph)));
      if (ts <= 2)               chk("R7 sts current", sts, exp_code(sp, wr));
      else if (ts == 5 && chain) chk("R7 sts queued in T4", sts, exp_code(csp, cwr));
      else                       chk("R7 sts passive", sts, 3'b111);
      chk("R11 req_ready in cycle", req_ready, n == 5 + 2*waits);
      chk("R8/R10 rd_valid", rd_valid, (n == 6 + 2*waits) && !iswr);
      if (n == 6 + 2*waits && !iswr)
        chk("R10/R12 rd_data", rd_data, exp_rd(wd, ad[0], din));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  sp, csp;
    logic        wr, wd, cwr, cwd;
    logic [19:0] ad, cad;
    logic [15:0] wdat, cwdat, din;
    logic [1:0]  sg, csg;
    bit          have_next, chain;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_word = 1'b0; req_space = '0; req_seg = '0; req_wdata = '0;
    ready = 1'b1; ad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 ale", ale, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 den_n", den_n, 1);
    chk("R1 bhe_n", bhe_n, 1);
    chk("R1 sts", sts, 3'b111);
    chk("R1 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 req_ready after release", req_ready, 1);

    // directed: word memory write, no wait
    run_cycle(2'd0, 1, 1, 20'hA1234, 16'hBEEF, 2'd1, 0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    // odd byte read with two waits
    run_cycle(2'd0, 0, 0, 20'h3_0011, 16'h0, 2'd2, 2, 16'hC35A, 0, 0, 0, 0, 0, 0, 0, 0);
    // odd byte write on the upper lane
    run_cycle(2'd0, 1, 0, 20'h5_FFFF, 16'h12A7, 2'd3, 1, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    // even byte read
    run_cycle(2'd0, 0, 0, 20'hF_0000, 16'h0, 2'd0, 0, 16'h9E3C, 0, 0, 0, 0, 0, 0, 0, 0);
    // R12 chain: I/O write -> interrupt ack (write flag set) -> code fetch (write flag set)
    run_cycle(2'd1, 1, 1, 20'h0_0042, 16'h55AA, 2'd0, 1, 16'h0, 0, 1,
              2'd3, 1, 1, 20'h0_0000, 16'hFFFF, 2'd0);
    run_cycle(2'd3, 1, 1, 20'h0_0000, 16'hFFFF, 2'd0, 0, 16'h0021, 1, 1,
              2'd2, 1, 1, 20'hF_FFF0, 16'h1111, 2'd1);
    run_cycle(2'd2, 1, 1, 20'hF_FFF0, 16'h1111, 2'd1, 0, 16'hEA90, 1, 0, 0, 0, 0, 0, 0, 0);
    // R8 long stall on an I/O read
    run_cycle(2'd1, 0, 1, 20'h0_03F8, 16'h0, 2'd2, 5, 16'h7E81, 0, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    have_next = 0;
    sp = 0; wr = 0; wd = 0; ad = 0; wdat = 0; sg = 0;
    for (int i = 0; i < 40; i++) begin
      bit pre;
      int waits;
      pre = have_next;
      if (!have_next) begin
        sp = 2'($urandom % 4); wr = 1'($urandom); wd = 1'($urandom);
        ad = 20'($urandom); wdat = 16'($urandom); sg = 2'($urandom % 4);
      end
      waits = $urandom % 4;
      din   = 16'($urandom);
      chain = (i < 39) && ($urandom % 3 == 0);
      csp = 2'($urandom % 4); cwr = 1'($urandom); cwd = 1'($urandom);
      cad = 20'($urandom); cwdat = 16'($urandom); csg = 2'($urandom % 4);
      run_cycle(sp, wr, wd, ad, wdat, sg, waits, din, pre, chain,
                csp, cwr, cwd, cad, cwdat, csg);
      have_next = chain;
      if (chain) begin
        sp = csp; wr = cwr; wd = cwd; ad = cad; wdat = cwdat; sg = csg;
      end
    end

    @(negedge clk);
    chk("R1 idle after traffic", sts, 3'b111);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule